// File: doc/BRIEF.md
# Addend-Compensated Precision Time Counter

This block keeps a 64-bit nanosecond time-of-day value that runs from one of four reference oscillators. On each edge of the chosen oscillator, a 32-bit phase accumulator absorbs a programmable addend. Whenever that sum carries out of bit 31, the time value moves forward by a programmed step in nanoseconds. Setting the addend to ceil(2^32 / R), where R is the oscillator frequency divided by the nominal tick frequency (1000 / step MHz) and R > 1, makes the carries arrive at the nominal rate on average. Software trims the rate in parts per billion by rewriting the addend while the counter runs. The largest usable trim is 1e9 × (R − 1) − 1 ppb.

Downstream logic uses the time output and a one-cycle tick strobe. Software reaches a small register port that holds the source select, the addend, the step and the time value. The port carries 32-bit words in either byte order. The clock switch is modelled as a plain multiplexer. Everything inside the block runs on the selected oscillator, and so does the register port.

Top module: `ptc_time_core`

## Requirements
- R1: After reset: time_o is 0, tick_o is low, the source select reads 1, the addend reads 0 and the step reads 10.
- R2: On every selected edge, the accumulator takes acc + addend modulo 2^32. tick_o is high for exactly the one cycle that follows each edge on which that sum carried. Starting from acc = 0, N accumulating edges give floor(N·A / 2^32) ticks.
- R3: On each edge that carries, time_o grows by the programmed step, so time_o equals step × ticks.
- R4: When no carry occurs and time is not written, time_o holds its value, for example with an addend of 0.
- R5: An addend write changes the value used from the following edge onward. The edge that stores the new addend still accumulates the old one.
- R6: Writing word 4 stores the upper time half in a holding register. Writing word 3 loads {holding, data} into time_o on that edge. If the same edge carries, the load wins and no step is added.
- R7: Word 0 bits [1:0] pick the reference: 0 external precision input, 1 system clock, 2 alternate clock, 3 RTC input; ref_clk_i[n] is source n.
- R8: With bus_le_i = 0 (the default, big-endian), write and read data are byte-reversed 32-bit words. With bus_le_i = 1 they pass unchanged.
- R9: With a 6 ns oscillator, a 10 ns step and addend ceil(2^32·3/5), a long run yields between edges·100/167 − 1 and edges·100/166 + 1 ticks.
- R10: Register words: 0 control, 1 addend, 2 step (8 bits, zero-extended on reads), 3 time bits [31:0], 4 time bits [63:32]. Words 3 and 4 read the live time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset, sampled on the selected oscillator |
| ref_clk_i | input | 4 | Reference oscillators, index equals source code |
| bus_le_i | input | 1 | Register data byte order: 0 reversed (big-endian), 1 straight |
| reg_wr_i | input | 1 | Register write strobe, one write per selected edge |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| time_o | output | 64 | Running time of day in nanoseconds |
| tick_o | output | 1 | One-cycle strobe after each accumulator carry |

## Verification
Two events can land on the same oscillator edge: a software load of the time value and an accumulator carry that would step it. The bench forces the overlap with an all-ones addend, which carries on every edge after the first. It then completes a time load. Sampled just after that edge, tick_o must be high and time_o must equal the loaded value exactly, with no step added. One cycle later, time_o must be that value plus one step. A second overlap pairs an addend rewrite with an accumulating edge. The single carry that follows shows that the edge which stored the rewrite still used the old addend.

// File: rtl/ptc_pkg.sv
// Shared constants, register word codes and byte-order helper for the
// precision time counter. Assumes a 32-bit register bus.
package ptc_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [2:0] {
        RA_CTRL    = 3'd0,
        RA_ADDEND  = 3'd1,
        RA_PERIOD  = 3'd2,
        RA_TIME_LO = 3'd3,
        RA_TIME_HI = 3'd4
    } reg_addr_e;

    // Reverse the byte lanes of one bus word.
    function automatic logic [BUS_W-1:0] lane_flip(input logic [BUS_W-1:0] w);
        logic [BUS_W-1:0] r;
        for (int b = 0; b < BUS_W / 8; b++) begin
            r[b*8 +: 8] = w[(BUS_W/8 - 1 - b)*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/ptc_clk_sel.sv
// Reference source multiplexer. Models a glitch-free switch as a plain
// select; assumes the switch is done off-chip or by a dedicated cell.
module ptc_clk_sel #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_SRC-1:0] clk_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               clk_o
);

    // Pick the requested source; out-of-range codes fall back to source 0.
    always_comb begin
        if (int'(sel_i) < NUM_SRC) clk_o = clk_i[sel_i];
        else                       clk_o = clk_i[0];
    end

endmodule

// File: rtl/ptc_phase_acc.sv
// Fractional phase accumulator. Adds the addend on every edge; the carry
// out is the nominal tick. Assumes addend is stable between edges.
module ptc_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] addend_i,
    output logic             carry_o,
    output logic             tick_o
);

    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] acc_q;
    logic             tick_q;
    logic             hist_ok;

    assign sum     = {1'b0, acc_q} + {1'b0, addend_i};
    assign carry_o = sum[ACC_W];
    assign tick_o  = tick_q;

    // Advance the phase and register the carry as a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= sum[ACC_W-1:0];
            tick_q <= sum[ACC_W];
        end
    end

    // Mark cycles that have a valid previous phase to compare against.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_ok <= 1'b0;
        else        hist_ok <= 1'b1;
    end

    AST_TICK_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |-> (tick_q == (acc_q < $past(acc_q)))); // R2

endmodule

// File: rtl/ptc_tod_counter.sv
// Time-of-day counter. Steps by the period on each carry; a software load
// takes precedence over the step on the same edge.
module ptc_tod_counter #(
    parameter int TIME_W = 64,
    parameter int PER_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic              load_i,
    input  logic [TIME_W-1:0] load_val_i,
    output logic [TIME_W-1:0] time_o
);

    localparam int PAD_W = TIME_W - PER_W;

    logic [TIME_W-1:0] time_q;

    assign time_o = time_q;

    // Load, step or hold the running time.
    always_ff @(posedge clk) begin
        if (!rst_n)      time_q <= '0;
        else if (load_i) time_q <= load_val_i;
        else if (step_i) time_q <= time_q + {{PAD_W{1'b0}}, period_i};
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_i)) |-> (time_q == $past(load_val_i))); // R6

    AST_STEP_BY_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_i) && $past(step_i))
        |-> (time_q == $past(time_q) + {{PAD_W{1'b0}}, $past(period_i)})); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_i) && !$past(step_i)) |-> $stable(time_q)); // R4

endmodule

// File: rtl/ptc_regs.sv
// Register port: source select, addend, period, time load and readback.
// Assumes one write per edge; data lanes reversed unless bus_le_i is set.
module ptc_regs
    import ptc_pkg::*;
#(
    parameter int ACC_W      = 32,
    parameter int PER_W      = 8,
    parameter int TIME_W     = 64,
    parameter int SEL_W      = 2,
    parameter int PERIOD_RST = 10,
    parameter int SEL_RST    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_le_i,
    input  logic              wr_i,
    input  logic [2:0]        addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    input  logic [TIME_W-1:0] time_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic [ACC_W-1:0]  addend_o,
    output logic [PER_W-1:0]  period_o,
    output logic              load_o,
    output logic [TIME_W-1:0] load_val_o
);

    localparam int HALF_W = TIME_W / 2;

    logic [BUS_W-1:0]  wd;
    logic [BUS_W-1:0]  rd_native;
    logic [SEL_W-1:0]  sel_q;
    logic [ACC_W-1:0]  addend_q;
    logic [PER_W-1:0]  period_q;
    logic [HALF_W-1:0] hi_hold_q;

    assign wd         = bus_le_i ? wdata_i : lane_flip(wdata_i);
    assign load_o     = wr_i && (addr_i == RA_TIME_LO);
    assign load_val_o = {hi_hold_q, wd[HALF_W-1:0]};
    assign sel_o      = sel_q;
    assign addend_o   = addend_q;
    assign period_o   = period_q;

    // Store software writes into the control fields and the upper-half hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= SEL_W'(SEL_RST);
            addend_q  <= '0;
            period_q  <= PER_W'(PERIOD_RST);
            hi_hold_q <= '0;
        end else if (wr_i) begin
            case (addr_i)
                RA_CTRL:    sel_q     <= wd[SEL_W-1:0];
                RA_ADDEND:  addend_q  <= wd[ACC_W-1:0];
                RA_PERIOD:  period_q  <= wd[PER_W-1:0];
                RA_TIME_HI: hi_hold_q <= wd[HALF_W-1:0];
                default: ;
            endcase
        end
    end

    // Select the addressed word in native order.
    always_comb begin
        case (addr_i)
            RA_CTRL:    rd_native = BUS_W'(sel_q);
            RA_ADDEND:  rd_native = BUS_W'(addend_q);
            RA_PERIOD:  rd_native = BUS_W'(period_q);
            RA_TIME_LO: rd_native = time_i[HALF_W-1:0];
            RA_TIME_HI: rd_native = time_i[TIME_W-1:HALF_W];
            default:    rd_native = '0;
        endcase
    end

    // Present read data in the bus byte order.
    always_comb begin
        rdata_o = bus_le_i ? rd_native : lane_flip(rd_native);
    end

    AST_SEL_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sel_q == SEL_W'(SEL_RST))); // R7

endmodule

// File: rtl/ptc_time_core.sv
// Top of the precision time counter: source mux, phase accumulator,
// time-of-day counter and register port, all on the selected oscillator.
module ptc_time_core #(
    parameter int NUM_REF    = 4,
    parameter int ACC_W      = 32,
    parameter int PER_W      = 8,
    parameter int TIME_W     = 64,
    parameter int PERIOD_RST = 10,
    parameter int SEL_RST    = 1
) (
    input  logic               rst_n,
    input  logic [NUM_REF-1:0] ref_clk_i,
    input  logic               bus_le_i,
    input  logic               reg_wr_i,
    input  logic [2:0]         reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic [TIME_W-1:0]  time_o,
    output logic               tick_o
);

    localparam int SEL_W = (NUM_REF > 1) ? $clog2(NUM_REF) : 1;

    logic              clk_ref;
    logic [SEL_W-1:0]  sel;
    logic [ACC_W-1:0]  addend;
    logic [PER_W-1:0]  period;
    logic              carry;
    logic              load;
    logic [TIME_W-1:0] load_val;

    ptc_clk_sel #(.NUM_SRC(NUM_REF), .SEL_W(SEL_W)) clk_sel_i (
        .clk_i (ref_clk_i),
        .sel_i (sel),
        .clk_o (clk_ref)
    );

    ptc_regs #(
        .ACC_W(ACC_W), .PER_W(PER_W), .TIME_W(TIME_W), .SEL_W(SEL_W),
        .PERIOD_RST(PERIOD_RST), .SEL_RST(SEL_RST)
    ) regs_i (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .bus_le_i   (bus_le_i),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .time_i     (time_o),
        .sel_o      (sel),
        .addend_o   (addend),
        .period_o   (period),
        .load_o     (load),
        .load_val_o (load_val)
    );

    ptc_phase_acc #(.ACC_W(ACC_W)) acc_i (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .addend_i (addend),
        .carry_o  (carry),
        .tick_o   (tick_o)
    );

    ptc_tod_counter #(.TIME_W(TIME_W), .PER_W(PER_W)) tod_i (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .step_i     (carry),
        .period_i   (period),
        .load_i     (load),
        .load_val_i (load_val),
        .time_o     (time_o)
    );

endmodule

// File: tb/ptc_time_core_tb_top.sv
`timescale 1ps/1ps
module ptc_time_core_tb_top;

    localparam int CLK_PERIOD_PS = 6000;   // system reference, source 1
    localparam int HALF0 = 2500;           // source 0, 5 ns
    localparam int HALF2 = 3500;           // source 2, 7 ns
    localparam int HALF3 = 15250;          // source 3, 30.5 ns
    localparam int MAX_CYC = 200000;

    // {addend, period, edges}
    localparam logic [71:0] VECS [4] = '{
        {32'h8000_0000, 16'd10, 24'd100},
        {32'h9999_99A4, 16'd10, 24'd167},
        {32'hFFFF_FFFF, 16'd8,  24'd50},
        {32'h4000_0000, 16'd3,  24'd64}
    };

    logic        clk0 = 0, clk1 = 0, clk2 = 0, clk3 = 0;
    logic        rst_n = 0;
    logic        bus_le = 0;
    logic        wr = 0;
    logic [2:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic [63:0] time_v;
    logic        tick;

    int checks = 0;
    int fails  = 0;

    always #HALF0 clk0 = ~clk0;
    always #(CLK_PERIOD_PS/2) clk1 = ~clk1;
    always #HALF2 clk2 = ~clk2;
    always #HALF3 clk3 = ~clk3;

    ptc_time_core dut_i (
        .rst_n       (rst_n),
        .ref_clk_i   ({clk3, clk2, clk1, clk0}),
        .bus_le_i    (bus_le),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .time_o      (time_v),
        .tick_o      (tick)
    );

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic chk_rng(input string req, input longint got, input longint lo, input longint hi);
        checks++;
        if (got < lo || got > hi) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d..%0d", req, got, lo, hi);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk1);
        rst_n = 1;
        @(negedge clk1);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk1);
        addr  = a;
        wdata = bus_le ? v : rev(v);
        wr    = 1;
        @(negedge clk1);
        wr    = 0;
    endtask

    task automatic rd_raw(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #100;
        v = rdata;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        logic [31:0] r;
        rd_raw(a, r);
        v = bus_le ? r : rev(r);
    endtask

    initial begin
        #(longint'(MAX_CYC) * CLK_PERIOD_PS);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [63:0] t0;
        longint      ticks;

        // R1: reset state
        do_reset();
        chk("R1 time", time_v, 64'd0);
        chk("R1 tick", {63'd0, tick}, 64'd0);
        rd_reg(3'd0, v); chk("R1 sel", {32'd0, v}, 64'd1);
        rd_reg(3'd1, v); chk("R1 addend", {32'd0, v}, 64'd0);
        rd_reg(3'd2, v); chk("R1 period", {32'd0, v}, 64'd10);

        // R4: zero addend holds time
        ticks = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk1);
            if (tick) ticks++;
        end
        chk("R4 ticks", 64'(ticks), 64'd0);
        chk("R4 time", time_v, 64'd0);

        // Vector table: R2 tick count and R3 time, exact from acc = 0
        for (int i = 0; i < 4; i++) begin
            logic [31:0] a;
            logic [15:0] p;
            logic [23:0] n;
            longint unsigned exp_t;
            {a, p, n} = VECS[i];
            do_reset();
            wr_reg(3'd2, {16'd0, p});
            wr_reg(3'd1, a);
            ticks = 0;
            for (int k = 0; k < int'(n); k++) begin
                @(negedge clk1);
                if (tick) ticks++;
            end
            exp_t = (longint'(n) * longint'(a)) >> 32;
            chk("R2 tick count", 64'(ticks), 64'(exp_t));
            chk("R3 time", time_v, 64'(exp_t * p));
        end

        // R5: edge that stores a new addend still uses the old one
        do_reset();
        wr_reg(3'd1, 32'h8000_0000);
        wr_reg(3'd1, 32'h0);
        chk("R5 tick", {63'd0, tick}, 64'd1);
        chk("R5 time", time_v, 64'd10);
        repeat (10) @(negedge clk1);
        chk("R5 hold", time_v, 64'd10);

        // R6: load and carry on the same edge
        do_reset();
        wr_reg(3'd1, 32'hFFFF_FFFF);
        repeat (5) @(negedge clk1);
        wr_reg(3'd4, 32'h0000_0001);
        wr_reg(3'd3, 32'd1000);
        chk("R6 carry same edge", {63'd0, tick}, 64'd1);
        chk("R6 load wins", time_v, 64'h0000_0001_0000_03E8);
        @(negedge clk1);
        chk("R6 step after", time_v, 64'h0000_0001_0000_03F2);
        // R10: live time readback
        rd_reg(3'd3, v); chk("R10 time lo", {32'd0, v}, {32'd0, time_v[31:0]});
        rd_reg(3'd4, v); chk("R10 time hi", {32'd0, v}, 64'd1);

        // R8: byte order
        do_reset();
        wr_reg(3'd2, 32'd5);
        rd_raw(3'd2, v); chk("R8 big-endian raw", {32'd0, v}, 64'h0500_0000);
        bus_le = 1;
        rd_raw(3'd2, v); chk("R8 little-endian raw", {32'd0, v}, 64'd5);
        bus_le = 0;

        // R7: switch to source 0 (5 ns) and measure the rate
        do_reset();
        wr_reg(3'd1, 32'h8000_0000);
        wr_reg(3'd0, 32'd0);
        repeat (4) @(negedge clk1);
        t0 = time_v;
        repeat (1000) @(negedge clk1);
        chk_rng("R7 source 0 rate", longint'(time_v - t0), 5980, 6020);
        wr_reg(3'd0, 32'd1);
        repeat (4) @(negedge clk1);
        t0 = time_v;
        repeat (1000) @(negedge clk1);
        chk_rng("R7 source 1 rate", longint'(time_v - t0), 4980, 5020);

        // R9: long-run rate at nominal addend
        do_reset();
        wr_reg(3'd1, 32'((64'd3 * (64'd1 << 32) + 64'd4) / 64'd5));
        ticks = 0;
        for (int k = 0; k < 16700; k++) begin
            @(negedge clk1);
            if (tick) ticks++;
        end
        chk_rng("R9 tick rate", ticks, 16700 * 100 / 167 - 1, 16700 * 100 / 166 + 1);
        chk("R9 time", time_v, 64'(ticks * 10));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule